// File: doc/BRIEF.md
# Packed SIMD Media ALU

This unit is a single functional slot of a media processor datapath. It takes two 64-bit operands (four for the averaging operation) and treats them as packed vectors of 8-, 16- or 32-bit elements. It performs one of five operations, selected per request:

- lane-wise add;
- lane-wise subtract;
- a byte-lane sum of absolute differences, as used in motion search;
- a rounded fractional high-half multiply on 16-bit lanes, as used in transforms;
- a rounded four-way byte average, as used in two-dimensional half-pixel interpolation.

Add and subtract can treat lanes as signed or unsigned, and can either wrap modulo the lane width or clip to the lane's range.

A request is presented with `in_valid` high together with its operation and mode selects. The registered result appears exactly one clock later with `out_valid` high. There is no stall, so a new request may be issued every cycle. Between requests the result register keeps its last value.

Top module: `simd_media_alu`

## Requirements
- R1: After reset, `out_valid` is 0 and `result` is 0. Each cycle, `out_valid` equals the `in_valid` of the previous cycle. The result of a request is on `result` in the cycle after the request is accepted.
- R2: In a cycle after one with `in_valid` low, `result` keeps the value it had before.
- R3: The `elem_size` select chooses the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 gives two 32-bit lanes. Lane i occupies bits [i*W +: W].
- R4: With `sat_en` = 0, opcode 0 (add) and opcode 1 (subtract, A minus B) return each lane's result modulo 2^W. This holds for both signed and unsigned lanes.
- R5: With `sat_en` = 1 and `is_signed` = 0, add and subtract clip each lane to the range 0 to 2^W-1.
- R6: With `sat_en` = 1 and `is_signed` = 1, add and subtract clip each lane to the range -2^(W-1) to 2^(W-1)-1.
- R7: Opcode 2 returns the sum of the absolute differences of the eight unsigned byte lanes of A and B, zero-extended to 64 bits, so the result is at most 2040. It ignores `elem_size`, `is_signed` and `sat_en`.
- R8: Opcode 3 treats A and B as four signed 16-bit lanes. Each lane returns bits 31:16 of (2*a*b + 0x8000). It ignores the mode selects.
- R9: In opcode 3, a lane with both inputs equal to 0x8000 returns 0x7FFF.
- R10: Opcode 4 returns, for each unsigned byte lane, (a+b+c+d+2)>>2, using operands A, B, C and D.
- R11: Opcodes 5 to 7 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (0 add, 1 sub, 2 SAD, 3 mulh, 4 avg4) |
| elem_size | input | 2 | Lane width select for add/sub |
| is_signed | input | 1 | Lanes are two's complement for add/sub |
| sat_en | input | 1 | Clip instead of wrap for add/sub |
| src_a | input | 64 | Operand A |
| src_b | input | 64 | Operand B |
| src_c | input | 64 | Operand C (average only) |
| src_d | input | 64 | Operand D (average only) |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
The assertions assume that the mode selects and operands are known whenever `in_valid` is high. They also assume that a request is judged against the selects sampled in that same cycle, since the unit has no handshake to hold them. The stimulus drives every input once per cycle on the falling edge and holds it through the next rising edge. Opcode, lane width, signedness and clip mode are drawn together at random, so every combination, including the reserved opcodes and lane-width code 3, reaches the unit. Directed vectors add the operand values that sit exactly on the clip limits, the multiply's single overflow pair and the largest SAD.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DW = 64;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SAD  = 3'd2,
    OP_MULH = 3'd3,
    OP_AVG4 = 3'd4
  } simd_op_e;

  // unsigned distance between two bytes
  function automatic logic [7:0] byte_absdiff(logic [7:0] x, logic [7:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  // fractional 16x16 product, rounded, upper half kept
  function automatic logic [15:0] q15_mul_round(logic [15:0] x, logic [15:0] y);
    logic signed [31:0] prod;
    logic signed [33:0] wide;
    logic signed [33:0] rnd;
    prod = $signed(x) * $signed(y);
    wide = {{2{prod[31]}}, prod};
    rnd  = (wide <<< 1) + 34'sd32768;
    if (x == 16'h8000 && y == 16'h8000) return 16'h7FFF;
    return rnd[31:16];
  endfunction

  // rounded mean of four bytes
  function automatic logic [7:0] quad_mean(logic [7:0] p, logic [7:0] q,
                                           logic [7:0] r, logic [7:0] s);
    logic [9:0] acc;
    acc = {2'b00, p} + {2'b00, q} + {2'b00, r} + {2'b00, s} + 10'd2;
    return acc[9:2];
  endfunction
endpackage

// File: rtl/simd_addsub_lanes.sv
module simd_addsub_lanes #(
  parameter int DW = 64,
  parameter int W  = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          sgn,
  input  logic          sat,
  output logic [DW-1:0] y,
  output logic          clamp_any
);
  localparam int N = DW / W;
  localparam logic signed [W+1:0] SMAX = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] SMIN = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [W+1:0] UMAX = {2'b00, {W{1'b1}}};

  logic [N-1:0] lane_clamp;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic signed [W+1:0] ea, eb, s, hi, lo;
    assign ea = sgn ? {{2{a[i*W+W-1]}}, a[i*W +: W]} : {2'b00, a[i*W +: W]};
    assign eb = sgn ? {{2{b[i*W+W-1]}}, b[i*W +: W]} : {2'b00, b[i*W +: W]};
    assign s  = sub ? (ea - eb) : (ea + eb);
    assign hi = sgn ? SMAX : UMAX;
    assign lo = sgn ? SMIN : '0;
    always_comb begin
      lane_clamp[i] = 1'b0;
      y[i*W +: W]   = s[W-1:0];
      if (sat && s > hi) begin
        y[i*W +: W]   = hi[W-1:0];
        lane_clamp[i] = 1'b1;
      end else if (sat && s < lo) begin
        y[i*W +: W]   = lo[W-1:0];
        lane_clamp[i] = 1'b1;
      end
    end
  end

  assign clamp_any = |lane_clamp;
endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int DW = 64,
  localparam int LANES = DW / 8,
  localparam int SW = $clog2(LANES * 255 + 1)
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [SW-1:0] sum
);
  import simd_pkg::*;
  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++)
      sum = sum + SW'(byte_absdiff(a[i*8 +: 8], b[i*8 +: 8]));
  end
endmodule

// File: rtl/simd_mulh.sv
module simd_mulh #(
  parameter int DW = 64,
  localparam int LANES = DW / 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          sat_hit
);
  import simd_pkg::*;
  logic [LANES-1:0] ovf;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign y[i*16 +: 16] = q15_mul_round(a[i*16 +: 16], b[i*16 +: 16]);
    assign ovf[i] = (a[i*16 +: 16] == 16'h8000) && (b[i*16 +: 16] == 16'h8000);
  end
  assign sat_hit = |ovf;
endmodule

// File: rtl/simd_avg4.sv
module simd_avg4 #(
  parameter int DW = 64,
  localparam int LANES = DW / 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] y
);
  import simd_pkg::*;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign y[i*8 +: 8] = quad_mean(a[i*8 +: 8], b[i*8 +: 8], c[i*8 +: 8], d[i*8 +: 8]);
  end
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
  import simd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [1:0]    elem_size,
  input  logic          is_signed,
  input  logic          sat_en,
  input  logic [63:0]   src_a,
  input  logic [63:0]   src_b,
  input  logic [63:0]   src_c,
  input  logic [63:0]   src_d,
  output logic          out_valid,
  output logic [63:0]   result
);
  localparam int NW = 3;
  localparam int SADW = $clog2((DW / 8) * 255 + 1);

  logic [DW-1:0]   as_res [NW];
  logic [NW-1:0]   as_clamp;
  logic [1:0]      wsel;
  logic            is_addsub;
  logic            clamp_sel;   // a lane of the selected width was clipped
  logic            mulh_sat;    // a multiply lane hit the overflow pair
  logic [SADW-1:0] sad_sum;
  logic [DW-1:0]   mulh_res, avg_res, nxt;

  for (genvar g = 0; g < NW; g++) begin : g_width
    simd_addsub_lanes #(.DW(DW), .W(8 << g)) u_as (
      .a(src_a), .b(src_b), .sub(op == OP_SUB), .sgn(is_signed), .sat(sat_en),
      .y(as_res[g]), .clamp_any(as_clamp[g])
    );
  end

  simd_sad  #(.DW(DW)) u_sad  (.a(src_a), .b(src_b), .sum(sad_sum));
  simd_mulh #(.DW(DW)) u_mulh (.a(src_a), .b(src_b), .y(mulh_res), .sat_hit(mulh_sat));
  simd_avg4 #(.DW(DW)) u_avg  (.a(src_a), .b(src_b), .c(src_c), .d(src_d), .y(avg_res));

  assign wsel      = (elem_size == 2'd3) ? 2'd2 : elem_size;
  assign is_addsub = (op == OP_ADD) || (op == OP_SUB);
  assign clamp_sel = is_addsub && as_clamp[wsel];

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: nxt = as_res[wsel];
      OP_SAD:         nxt = {{(DW-SADW){1'b0}}, sad_sum};
      OP_MULH:        nxt = mulh_res;
      OP_AVG4:        nxt = avg_res;
      default:        nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/simd_media_alu_chk.sv
module simd_media_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic        is_signed,
  input logic        sat_en,
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic [63:0] src_c,
  input logic [63:0] src_d,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        clamp_sel,
  input logic        mulh_sat
);
  localparam logic [63:0] NEG_ONE_Q15 = 64'h8000_8000_8000_8000;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_ADD_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd0 && src_b == '0 |=> result == $past(src_a)); // R4
  AST_WRAP_NO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !sat_en |-> !clamp_sel); // R4
  AST_USUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd1 && sat_en && !is_signed && src_a == src_b |=> result == '0); // R5
  AST_SAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd2 |=> result <= 64'd2040); // R7
  AST_MULH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd3 && src_a[15:0] == 16'h8000 && src_b[15:0] == 16'h8000 |-> mulh_sat); // R9
  AST_MULH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd3 && src_a == NEG_ONE_Q15 && src_b == NEG_ONE_Q15
    |=> result == 64'h7FFF_7FFF_7FFF_7FFF); // R9
  AST_AVG_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd4 && src_a == src_b && src_b == src_c && src_c == src_d
    |=> result == $past(src_a)); // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op >= 3'd5 |=> result == '0); // R11
  AST_OUT_VALID_DEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R1
endmodule

bind simd_media_alu simd_media_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .is_signed(is_signed),
  .sat_en(sat_en), .src_a(src_a), .src_b(src_b), .src_c(src_c), .src_d(src_d),
  .out_valid(out_valid), .result(result), .clamp_sel(clamp_sel), .mulh_sat(mulh_sat)
);

// File: tb/test_simd_media_alu.sv
`timescale 1ns/1ps
module test_simd_media_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  elem_size = '0;
  logic        is_signed = 1'b0;
  logic        sat_en = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, src_c = '0, src_d = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  simd_media_alu i_simd_media_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .elem_size(elem_size),
    .is_signed(is_signed), .sat_en(sat_en), .src_a(src_a), .src_b(src_b),
    .src_c(src_c), .src_d(src_d), .out_valid(out_valid), .result(result)
  );

  // independent reference built straight from the requirement text
  function automatic logic [63:0] ref_model(int o, int es, bit sg, bit st,
                                            logic [63:0] a, logic [63:0] b,
                                            logic [63:0] c, logic [63:0] d);
    logic [63:0] r = '0;
    int w;
    longint x, y, s, mask, hi, lo;
    case (o)
      0, 1: begin
        w = (es >= 2) ? 32 : (8 << es);
        mask = (longint'(1) << w) - 1;
        for (int i = 0; i < 64 / w; i++) begin
          x = longint'(a >> (i * w)) & mask;
          y = longint'(b >> (i * w)) & mask;
          if (sg && x[w-1]) x = x - (longint'(1) << w);
          if (sg && y[w-1]) y = y - (longint'(1) << w);
          s = (o == 1) ? x - y : x + y;
          if (st) begin
            hi = sg ? (longint'(1) << (w - 1)) - 1 : mask;
            lo = sg ? -(longint'(1) << (w - 1)) : 0;
            if (s > hi) s = hi;
            if (s < lo) s = lo;
          end
          r = r | (64'(s & mask) << (i * w));
        end
      end
      2: begin
        s = 0;
        for (int i = 0; i < 8; i++) begin
          x = longint'(a >> (i * 8)) & 255;
          y = longint'(b >> (i * 8)) & 255;
          s = s + ((x > y) ? x - y : y - x);
        end
        r = 64'(s);
      end
      3: begin
        for (int i = 0; i < 4; i++) begin
          x = longint'(a >> (i * 16)) & 65535;
          y = longint'(b >> (i * 16)) & 65535;
          if (x >= 32768) x = x - 65536;
          if (y >= 32768) y = y - 65536;
          if (x == -32768 && y == -32768) s = 32767;
          else s = (2 * x * y + 32768) >>> 16;
          r = r | (64'(s & 65535) << (i * 16));
        end
      end
      4: begin
        for (int i = 0; i < 8; i++) begin
          s = (longint'(a >> (i * 8)) & 255) + (longint'(b >> (i * 8)) & 255)
            + (longint'(c >> (i * 8)) & 255) + (longint'(d >> (i * 8)) & 255) + 2;
          r = r | (64'((s >> 2) & 255) << (i * 8));
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one request; result sampled one time step after the capturing edge
  task automatic issue(string tag, int o, int es, bit sg, bit st,
                       logic [63:0] a, logic [63:0] b, logic [63:0] c, logic [63:0] d,
                       logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op = 3'(o); elem_size = 2'(es); is_signed = sg; sat_en = st;
    src_a = a; src_b = b; src_c = c; src_d = d;
    @(posedge clk); #1;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, exp);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, c, d, held;
    int o, es;
    bit sg, st;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    issue("R4 byte wrap add", 0, 0, 0, 0, {8{8'hFF}}, {8{8'h01}}, 0, 0, 64'd0);
    issue("R4 signed wrap sub", 1, 1, 1, 0, {4{16'h8000}}, {4{16'h0001}}, 0, 0, {4{16'h7FFF}});
    issue("R5 unsigned clip add", 0, 0, 0, 1, {8{8'hFF}}, {8{8'h01}}, 0, 0, {8{8'hFF}});
    issue("R5 unsigned clip sub", 1, 2, 0, 1, {2{32'd5}}, {2{32'd7}}, 0, 0, 64'd0);
    issue("R6 signed clip add", 0, 0, 1, 1, {8{8'h7F}}, {8{8'h01}}, 0, 0, {8{8'h7F}});
    issue("R6 signed clip sub", 1, 0, 1, 1, {8{8'h80}}, {8{8'h01}}, 0, 0, {8{8'h80}});
    issue("R3 half lanes", 0, 1, 0, 0, 64'h0001_FFFF_00FF_1234, 64'h0001_0001_0001_0001,
          0, 0, 64'h0002_0000_0100_1235);
    issue("R3 size code 3", 0, 3, 0, 0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0001_0000_0001,
          0, 0, 64'h0000_0002_0000_0000);
    issue("R7 SAD max", 2, 1, 1, 1, {8{8'hFF}}, 64'd0, 0, 0, 64'd2040);
    issue("R8 mulh round", 3, 0, 0, 0, 64'h4000_FFFF_7FFF_0100, 64'h4000_0001_7FFF_0100,
          0, 0, 64'h2000_0000_7FFE_0002);
    issue("R9 mulh overflow", 3, 0, 0, 0, {4{16'h8000}}, {4{16'h8000}}, 0, 0, {4{16'h7FFF}});
    issue("R10 avg round", 4, 0, 0, 0, {8{8'hFF}}, {8{8'hFF}}, {8{8'hFF}}, {8{8'h01}},
          {8{8'hC0}});
    issue("R11 reserved op", 6, 0, 0, 0, {8{8'h55}}, {8{8'h11}}, 0, 0, 64'd0);

    // R2: idle cycle with new operands leaves result and clears valid
    issue("R10 avg", 4, 0, 0, 0, 64'd4, 64'd4, 64'd4, 64'd4, 64'd4);
    held = result;
    @(negedge clk);
    src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; op = 3'd0;
    @(posedge clk); #1;
    check("R2 hold result", result, held);
    check("R1 idle valid", {63'd0, out_valid}, 64'd0);

    for (int k = 0; k < 3000; k++) begin
      o  = int'($urandom_range(7, 0));
      es = int'($urandom_range(3, 0));
      sg = 1'($urandom); st = 1'($urandom);
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      c = {$urandom, $urandom}; d = {$urandom, $urandom};
      if (k % 7 == 0) b = a ^ {8{8'h80}};
      issue("R3 R4 R5 R6 R7 R8 R10 R11 random", o, es, sg, st, a, b, c, d,
            ref_model(o, es, sg, st, a, b, c, d));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule